// File: doc/BRIEF.md
# Prioritized PCI-to-Host Window Decoder

This block claims inbound PCI target accesses for a host processor bus. It holds four programmable windows. Each window has an inclusive range in the upper half of the 32-bit PCI address, separate enables for reads and writes, a write-posting enable, a host transfer-type code, and a 16-bit offset. For each access presented, the block decides which window, if any, claims it. It then forms the host address by adding the winning window's offset to the upper address half. The lower half passes through unchanged.

Software or a configuration agent programs the windows through a simple write port, one 16-bit register at a time. Windows may overlap. A fixed priority resolves any overlap, and window 0 wins over all the others. The decode result is registered, so it appears one clock after the access is sampled. Bus protocol sequencing and the data path stay with the surrounding logic.

Top module: `pci_win_decoder`

## Requirements
- R1: After reset, every window has its read, write and posting enables cleared. No access hits, and all outputs read zero.
- R2: A valid access hits window n when start_n <= acc_addr_i[31:16] <= end_n, and only the upper 16 address bits take part in the compare. Both bounds are inclusive.
- R3: A read hits only a window whose read enable is set. A write hits only a window whose write enable is set. An access that matches a range but not the enable for its direction is not claimed.
- R4: On a hit, host_addr_o[31:16] = (acc_addr_i[31:16] + offset) mod 2^16, and host_addr_o[15:0] = acc_addr_i[15:0].
- R5: When several windows hit, the one with the lowest index wins, and win_o reports its index.
- R6: post_o is 1 only for a write that hits a window whose posting enable is set. It is 0 for every read.
- R7: xfer_type_o carries the transfer-type field of the winning window.
- R8: When acc_valid_i is 0 or no window hits, hit_o, win_o, host_addr_o, post_o and xfer_type_o are all 0.
- R9: The outputs change one clock after the access is sampled. Configuration port: cfg_reg_i 0 = start, 1 = end, 2 = offset, 3 = attributes. In the attribute register, bit 0 = read enable, bit 1 = write enable, bit 2 = posting enable, and bits 7:4 = transfer type. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_win_i | input | 2 | Window selected for the write |
| cfg_reg_i | input | 2 | Register selected within the window |
| cfg_wdata_i | input | 16 | Configuration write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 32 | PCI address |
| hit_o | output | 1 | Access claimed by a window |
| win_o | output | 2 | Index of the winning window |
| host_addr_o | output | 32 | Translated host address |
| post_o | output | 1 | Write may be posted |
| xfer_type_o | output | 4 | Host transfer type of the winning window |

## Verification
The assertions assume that the access inputs hold defined values on every clock edge after reset, including cycles with acc_valid_i low. Their checks of past-cycle address and direction rely on this. The bench parks the access inputs at zero between accesses. It changes both the access and configuration inputs only on falling edges, so every sampled value is settled and defined. The bench does not reprogram a window while an access is being decoded, because the assertions do not cover the case where configuration and decode happen in the same cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int ADDR_W        = 32;
  localparam int HI_W          = 16;
  localparam int TYPE_W        = 4;
  localparam int ATTR_RD       = 0;
  localparam int ATTR_WR       = 1;
  localparam int ATTR_POST     = 2;
  localparam int ATTR_TYPE_LSB = 4;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_OFF  = 2'd2,
    REG_ATTR = 2'd3
  } cfg_reg_e;

  typedef struct packed {
    logic [HI_W-1:0]   lo;
    logic [HI_W-1:0]   hi;
    logic [HI_W-1:0]   off;
    logic              rd_en;
    logic              wr_en;
    logic              post_en;
    logic [TYPE_W-1:0] xtype;
  } win_cfg_t;
endpackage

// File: rtl/pwd_cfg_regs.sv
module pwd_cfg_regs
  import pwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [1:0]      reg_i,
  input  logic [HI_W-1:0] wdata_i,
  output win_cfg_t        cfg_o [NUM_WIN]
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (we_i && (win_i == WIN_W'(w))) begin
        unique case (cfg_reg_e'(reg_i))
          REG_LO:  cfg_q.lo  <= wdata_i;
          REG_HI:  cfg_q.hi  <= wdata_i;
          REG_OFF: cfg_q.off <= wdata_i;
          REG_ATTR: begin
            cfg_q.rd_en   <= wdata_i[ATTR_RD];
            cfg_q.wr_en   <= wdata_i[ATTR_WR];
            cfg_q.post_en <= wdata_i[ATTR_POST];
            cfg_q.xtype   <= wdata_i[ATTR_TYPE_LSB +: TYPE_W];
          end
          default: ;
        endcase
      end
    end
    assign cfg_o[w] = cfg_q;
  end
endmodule

// File: rtl/pwd_win_match.sv
module pwd_win_match
  import pwd_pkg::*;
(
  input  win_cfg_t        cfg_i,
  input  logic [HI_W-1:0] hi_addr_i,
  input  logic            write_i,
  output logic            hit_o
);
  logic in_range;
  logic dir_ok;
  assign in_range = (hi_addr_i >= cfg_i.lo) && (hi_addr_i <= cfg_i.hi);
  assign dir_ok   = write_i ? cfg_i.wr_en : cfg_i.rd_en;
  assign hit_o    = in_range && dir_ok;
endmodule

// File: rtl/pwd_prio_pick.sv
module pwd_prio_pick #(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit_i,
  output logic               any_o,
  output logic [WIN_W-1:0]   idx_o
);
  // lowest index wins: scan from the top so the last match kept is the lowest
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = WIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/pci_win_decoder.sv
module pci_win_decoder
  import pwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WIN_W-1:0]  cfg_win_i,
  input  logic [1:0]        cfg_reg_i,
  input  logic [HI_W-1:0]   cfg_wdata_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              hit_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [ADDR_W-1:0] host_addr_o,
  output logic              post_o,
  output logic [TYPE_W-1:0] xfer_type_o
);
  localparam int LO_W = ADDR_W - HI_W;

  win_cfg_t             cfg [NUM_WIN];
  logic [NUM_WIN-1:0]   raw_hit;
  logic [NUM_WIN-1:0]   hit_vec;
  logic                 any_hit;
  logic [WIN_W-1:0]     pick;
  win_cfg_t             sel_cfg;
  logic [HI_W-1:0]      hi_addr;

  assign hi_addr = acc_addr_i[ADDR_W-1:LO_W];

  pwd_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .win_i   (cfg_win_i),
    .reg_i   (cfg_reg_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    pwd_win_match u_match (
      .cfg_i     (cfg[w]),
      .hi_addr_i (hi_addr),
      .write_i   (acc_write_i),
      .hit_o     (raw_hit[w])
    );
  end

  assign hit_vec = raw_hit & {NUM_WIN{acc_valid_i}};

  pwd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (pick)
  );

  assign sel_cfg = cfg[pick];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      win_o       <= '0;
      host_addr_o <= '0;
      post_o      <= 1'b0;
      xfer_type_o <= '0;
    end else if (any_hit) begin
      hit_o       <= 1'b1;
      win_o       <= pick;
      host_addr_o <= {hi_addr + sel_cfg.off, acc_addr_i[LO_W-1:0]};
      post_o      <= acc_write_i && sel_cfg.post_en;
      xfer_type_o <= sel_cfg.xtype;
    end else begin
      hit_o       <= 1'b0;
      win_o       <= '0;
      host_addr_o <= '0;
      post_o      <= 1'b0;
      xfer_type_o <= '0;
    end
  end
endmodule

// File: rtl/pwd_chk.sv
module pwd_chk
  import pwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              hit_o,
  input logic [WIN_W-1:0]  win_o,
  input logic [ADDR_W-1:0] host_addr_o,
  input logic              post_o,
  input logic [TYPE_W-1:0] xfer_type_o
);
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !hit_o); // R8
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (host_addr_o == '0) && !post_o && (xfer_type_o == '0) && (win_o == '0)); // R8
  AST_POST_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |=> !post_o); // R6
  AST_POST_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_o |-> hit_o); // R6
  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> (!hit_o || (host_addr_o[HI_W-1:0] == $past(acc_addr_i[HI_W-1:0])))); // R4
endmodule

bind pci_win_decoder pwd_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_addr_i  (acc_addr_i),
  .hit_o       (hit_o),
  .win_o       (win_o),
  .host_addr_o (host_addr_o),
  .post_o      (post_o),
  .xfer_type_o (xfer_type_o)
);

// File: tb/sim_pci_win_decoder.sv
module sim_pci_win_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_win_i = '0;
  logic [1:0]  cfg_reg_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        hit_o;
  logic [1:0]  win_o;
  logic [31:0] host_addr_o;
  logic        post_o;
  logic [3:0]  xfer_type_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pci_win_decoder u0 (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] w, input logic [1:0] r, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_win_i = w; cfg_reg_i = r; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // attr: [0] rd, [1] wr, [2] post, [7:4] type
  task automatic set_win(input logic [1:0] w, input logic [15:0] lo, input logic [15:0] hi,
                         input logic [15:0] off, input logic [15:0] attr);
    cfg_wr(w, 2'd0, lo);
    cfg_wr(w, 2'd1, hi);
    cfg_wr(w, 2'd2, off);
    cfg_wr(w, 2'd3, attr);
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic wr,
                        input logic e_hit, input logic [1:0] e_win, input logic [31:0] e_host,
                        input logic e_post, input logic [3:0] e_type);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_addr_i = a;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_write_i = 1'b0; acc_addr_i = '0;
    chk(req, "hit", 64'(hit_o), 64'(e_hit));
    chk(req, "win", 64'(win_o), 64'(e_win));
    chk(req, "host", 64'(host_addr_o), 64'(e_host));
    chk(req, "post", 64'(post_o), 64'(e_post));
    chk(req, "type", 64'(xfer_type_o), 64'(e_type));
  endtask

  task automatic t_reset;
    chk("R1", "hit after reset", 64'(hit_o), 64'd0);
    chk("R1", "host after reset", 64'(host_addr_o), 64'd0);
    access("R1", 32'h0000_1234, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
    access("R1", 32'h0000_1234, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
  endtask

  task automatic t_bounds;
    set_win(2'd2, 16'h1000, 16'h1FFF, 16'h2000, 16'h0053);
    access("R2", 32'h0FFF_FFFF, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
    access("R2", 32'h1000_0004, 1'b0, 1'b1, 2'd2, 32'h3000_0004, 1'b0, 4'h5);
    access("R7", 32'h1FFF_ABCD, 1'b1, 1'b1, 2'd2, 32'h3FFF_ABCD, 1'b0, 4'h5);
    access("R2", 32'h2000_0000, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
  endtask

  task automatic t_direction;
    set_win(2'd1, 16'h4000, 16'h40FF, 16'h0000, 16'h0096); // wr+post, type 9
    access("R3", 32'h4010_0000, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
    access("R6", 32'h4010_0008, 1'b1, 1'b1, 2'd1, 32'h4010_0008, 1'b1, 4'h9);
    set_win(2'd3, 16'h5000, 16'h5000, 16'h0001, 16'h0015); // rd+post, type 1
    access("R6", 32'h5000_0010, 1'b0, 1'b1, 2'd3, 32'h5001_0010, 1'b0, 4'h1);
    access("R3", 32'h5000_0010, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0);
  endtask

  task automatic t_wrap;
    set_win(2'd0, 16'hF000, 16'hFFFF, 16'h2000, 16'h00A3);
    access("R4", 32'hF800_1111, 1'b0, 1'b1, 2'd0, 32'h1800_1111, 1'b0, 4'hA);
    cfg_wr(2'd0, 2'd2, 16'hFFFF); // offset -1
    access("R4", 32'hF000_0000, 1'b1, 1'b1, 2'd0, 32'hEFFF_0000, 1'b0, 4'hA);
  endtask

  task automatic t_priority;
    set_win(2'd1, 16'h1800, 16'h18FF, 16'h0000, 16'h0073);
    access("R5", 32'h1850_0000, 1'b0, 1'b1, 2'd1, 32'h1850_0000, 1'b0, 4'h7);
    access("R5", 32'h1900_0000, 1'b0, 1'b1, 2'd2, 32'h3900_0000, 1'b0, 4'h5);
    set_win(2'd0, 16'h0000, 16'hFFFF, 16'h0100, 16'h00C3);
    access("R5", 32'h1850_0002, 1'b1, 1'b1, 2'd0, 32'h1950_0002, 1'b0, 4'hC);
    cfg_wr(2'd0, 2'd3, 16'h0000); // disable window 0 again
    access("R5", 32'h1850_0002, 1'b1, 1'b1, 2'd1, 32'h1850_0002, 1'b0, 4'h7);
  endtask

  task automatic t_idle_and_latency;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_addr_i = 32'h1000_0000; acc_write_i = 1'b0;
    @(negedge clk_i);
    chk("R8", "hit with valid low", 64'(hit_o), 64'd0);
    chk("R8", "host with valid low", 64'(host_addr_o), 64'd0);
    acc_valid_i = 1'b1;
    #1;
    chk("R9", "hit before edge", 64'(hit_o), 64'd0);
    @(negedge clk_i);
    chk("R9", "hit after one edge", 64'(hit_o), 64'd1);
    acc_valid_i = 1'b0; acc_addr_i = '0;
    @(negedge clk_i);
    chk("R9", "hit drops after one edge", 64'(hit_o), 64'd0);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bounds();
    t_direction();
    t_wrap();
    t_priority();
    t_idle_and_latency();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule